// File: doc/BRIEF.md
# Memory Module Write Receiver

This block is the receive-side control of a memory module on a shared module bus. Every bus transfer carries a destination code, a source code, an opcode and a data field. The receiver watches each transfer for its own module number. A write opcode addressed to it starts an access. The receiver keeps the requester's source code, the opcode and the address (the low bits of the data field) in locked registers. It then lowers its ready line, so no other module can start an access while this one is open.

The operand comes in a later transfer on the same bus. The receiver takes it only when the destination code and the locked source code both match. The opcode in that transfer is not used: the operation was fixed when the address was captured. An accepted operand goes into a write-data register and starts a write timing sequence of fixed length into a small internal RAM. At the end of the sequence the locks release and the ready line goes high again. A combinational read port lets the contents of the RAM be observed.

Top module: `mem_bus_rx`

## Requirements
- R1: After reset the ready line is high and every RAM word reads zero.
- R2: While ready is high, a valid transfer with destination equal to MOD_ID and opcode write (2'd2) captures the source code, the opcode and the address (data bits [ADDR_W-1:0]). Ready is low from the next cycle.
- R3: While ready is low, the locked source, opcode and address do not change. An address transfer from another module cannot open a new access.
- R4: While locked, a transfer is accepted as the operand only when its destination equals MOD_ID and its source equals the locked source. A transfer with a matching destination and a different source is ignored, and the lock is kept.
- R5: The opcode field of the operand transfer is ignored (normally nop, 2'd0). The write comes from the opcode latched with the address.
- R6: WR_CYCLES clock edges after the edge that accepts the operand, the locked address holds the operand and ready is high again.
- R7: A transfer whose destination differs from MOD_ID changes no register, the ready line or the RAM, whether the block is idle or locked.
- R8: While idle, a transfer to this module with opcode nop (2'd0), read (2'd1) or command (2'd3) is ignored, and ready stays high.
- R9: Ready stays low for every cycle of the write timing sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | A transfer is on the bus this cycle |
| bus_dest_i | input | ID_W | Destination module code |
| bus_src_i | input | ID_W | Source module code |
| bus_op_i | input | 2 | Memory opcode |
| bus_data_i | input | DATA_W | Address (low bits) or operand |
| rdy_o | output | 1 | High when the module can take a new address |
| rd_addr_i | input | ADDR_W | Observation read address |
| rd_data_o | output | DATA_W | RAM word at rd_addr_i |

## Verification
The bench builds the block with MOD_ID=5, ADDR_W=4, DATA_W=16 and WR_CYCLES=3. The short write sequence lets the bench sample ready at the last busy edge and at the release edge in every transaction. The 16-word RAM lets a wrong-source operand, a foreign-destination operand and a second requester's address each be shown to leave a neighbouring word untouched. The non-default module number confirms that the destination comparator decodes the parameter and not a hard-wired code.

// File: rtl/mem_bus_rx_pkg.sv
package mem_bus_rx_pkg;
  localparam int unsigned OP_W = 2;
  localparam logic [OP_W-1:0] OP_NOP   = 2'd0;
  localparam logic [OP_W-1:0] OP_READ  = 2'd1;
  localparam logic [OP_W-1:0] OP_WRITE = 2'd2;
  localparam logic [OP_W-1:0] OP_CMD   = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOCK  = 2'd1,
    ST_WRITE = 2'd2
  } st_e;
endpackage

// File: rtl/mem_bus_rx_cmp.sv
module mem_bus_rx_cmp #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] bit_eq;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end
  assign eq_o = &bit_eq;
endmodule

// File: rtl/mem_bus_rx_ram.sv
module mem_bus_rx_ram #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] rows [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   rows[i] <= '0;
      else if (we_i && (waddr_i == ADDR_W'(i)))      rows[i] <= wdata_i;
    end
  end

  assign rdata_o = rows[raddr_i];
endmodule

// File: rtl/mem_bus_rx_ctl.sv
module mem_bus_rx_ctl
  import mem_bus_rx_pkg::*;
#(
  parameter int unsigned ID_W      = 3,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WR_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [ID_W-1:0]   bus_src_i,
  input  logic [OP_W-1:0]   bus_op_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              dest_hit_i,
  input  logic              src_hit_i,
  output logic              rdy_o,
  output st_e               st_o,
  output logic [ID_W-1:0]   lk_src_o,
  output logic [OP_W-1:0]   lk_op_o,
  output logic [ADDR_W-1:0] lk_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              ram_we_o
);
  localparam int unsigned CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             take_addr, take_data, cnt_done;

  assign take_addr = (st_q == ST_IDLE) && bus_valid_i && dest_hit_i && (bus_op_i == OP_WRITE);
  // operand: opcode field deliberately ignored
  assign take_data = (st_q == ST_LOCK) && bus_valid_i && dest_hit_i && src_hit_i;
  assign cnt_done  = (cnt_q == CNT_LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (take_addr) st_d = ST_LOCK;
      ST_LOCK:  if (take_data) st_d = (lk_op_o == OP_WRITE) ? ST_WRITE : ST_IDLE;
      ST_WRITE: if (cnt_done)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      lk_src_o  <= '0;
      lk_op_o   <= OP_NOP;
      lk_addr_o <= '0;
      wdata_o   <= '0;
    end else begin
      st_q <= st_d;
      if (take_addr) begin
        lk_src_o  <= bus_src_i;
        lk_op_o   <= bus_op_i;
        lk_addr_o <= bus_data_i[ADDR_W-1:0];
      end
      if (take_data) begin
        wdata_o <= bus_data_i;
        cnt_q   <= '0;
      end else if (st_q == ST_WRITE) begin
        cnt_q <= cnt_done ? '0 : cnt_q + CNT_W'(1);
      end
    end
  end

  assign ram_we_o = (st_q == ST_WRITE) && cnt_done;
  assign rdy_o    = (st_q == ST_IDLE);
  assign st_o     = st_q;
endmodule

// File: rtl/mem_bus_rx.sv
module mem_bus_rx
  import mem_bus_rx_pkg::*;
#(
  parameter int unsigned MOD_ID    = 3,
  parameter int unsigned ID_W      = 3,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned WR_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic [ID_W-1:0]   bus_dest_i,
  input  logic [ID_W-1:0]   bus_src_i,
  input  logic [1:0]        bus_op_i,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic              rdy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ID_W-1:0] OWN_ID = ID_W'(MOD_ID);

  logic              dest_hit, src_hit, ram_we;
  st_e               st;
  logic [ID_W-1:0]   lk_src;
  logic [OP_W-1:0]   lk_op;
  logic [ADDR_W-1:0] lk_addr;
  logic [DATA_W-1:0] wdata;

  mem_bus_rx_cmp #(.W(ID_W)) u_dest_cmp (
    .a_i (bus_dest_i),
    .b_i (OWN_ID),
    .eq_o(dest_hit)
  );

  mem_bus_rx_cmp #(.W(ID_W)) u_src_cmp (
    .a_i (bus_src_i),
    .b_i (lk_src),
    .eq_o(src_hit)
  );

  mem_bus_rx_ctl #(
    .ID_W     (ID_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WR_CYCLES(WR_CYCLES)
  ) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_valid_i(bus_valid_i),
    .bus_src_i  (bus_src_i),
    .bus_op_i   (bus_op_i),
    .bus_data_i (bus_data_i),
    .dest_hit_i (dest_hit),
    .src_hit_i  (src_hit),
    .rdy_o      (rdy_o),
    .st_o       (st),
    .lk_src_o   (lk_src),
    .lk_op_o    (lk_op),
    .lk_addr_o  (lk_addr),
    .wdata_o    (wdata),
    .ram_we_o   (ram_we)
  );

  mem_bus_rx_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ram_we),
    .waddr_i(lk_addr),
    .wdata_i(wdata),
    .raddr_i(rd_addr_i),
    .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/mem_bus_rx_chk.sv
module mem_bus_rx_chk
  import mem_bus_rx_pkg::*;
#(
  parameter int unsigned MOD_ID = 3,
  parameter int unsigned ID_W   = 3,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic [ID_W-1:0]   bus_dest_i,
  input logic [ID_W-1:0]   bus_src_i,
  input logic [1:0]        bus_op_i,
  input logic              rdy_o,
  input st_e               st,
  input logic [ID_W-1:0]   lk_src,
  input logic [1:0]        lk_op,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              ram_we
);
  logic hit;
  assign hit = bus_valid_i && (bus_dest_i == ID_W'(MOD_ID));

  p_addr_lock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && hit && (bus_op_i == OP_WRITE) |=> !rdy_o);

  p_lock_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_o |=> $stable(lk_src) && $stable(lk_op) && $stable(lk_addr));

  p_src_mismatch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_LOCK) && hit && (bus_src_i != lk_src) |=> (st == ST_LOCK));

  p_write_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |=> rdy_o);

  p_foreign_dest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && bus_valid_i && (bus_dest_i != ID_W'(MOD_ID)) |=> rdy_o);

  p_nonwrite_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o && hit && (bus_op_i != OP_WRITE) |=> rdy_o);

  p_busy_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WRITE) |-> !rdy_o);
endmodule

bind mem_bus_rx mem_bus_rx_chk #(
  .MOD_ID(MOD_ID),
  .ID_W  (ID_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .bus_dest_i (bus_dest_i),
  .bus_src_i  (bus_src_i),
  .bus_op_i   (bus_op_i),
  .rdy_o      (rdy_o),
  .st         (st),
  .lk_src     (lk_src),
  .lk_op      (lk_op),
  .lk_addr    (lk_addr),
  .ram_we     (ram_we)
);

// File: tb/mem_bus_rx_bench.sv
`timescale 1ns/1ps
module mem_bus_rx_bench;
  localparam int unsigned MOD_ID = 5;
  localparam int unsigned ID_W   = 3;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned WRC    = 3;
  localparam time         CLK_P  = 20ns;
  localparam logic [2:0]  ME     = 3'(MOD_ID);
  localparam logic [1:0]  NOP = 2'd0, RD = 2'd1, WR = 2'd2, CMD = 2'd3;

  localparam int unsigned NV = 4;
  localparam logic [2:0]  V_SRC  [NV] = '{3'd1, 3'd2, 3'd7, 3'd0};
  localparam logic [3:0]  V_ADDR [NV] = '{4'd0, 4'd15, 4'd6, 4'd3};
  localparam logic [15:0] V_DATA [NV] = '{16'hA5A5, 16'h0001, 16'hFFFF, 16'h1234};
  localparam logic [1:0]  V_DOP  [NV] = '{NOP, RD, CMD, WR};

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [ID_W-1:0]   dest = '0, src = '0;
  logic [1:0]        op = '0;
  logic [DATA_W-1:0] data = '0;
  logic              rdy;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DATA_W-1:0] rd_data;
  int                total = 0, bad = 0;
  bit                done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mem_bus_rx #(
    .MOD_ID(MOD_ID), .ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WRC)
  ) u_mem_bus_rx (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_dest_i(dest),
    .bus_src_i(src), .bus_op_i(op), .bus_data_i(data), .rdy_o(rdy),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one-cycle transfer; returns at the negedge after the capturing edge
  task automatic xfer(input logic [2:0] d, input logic [2:0] s, input logic [1:0] o,
                      input logic [15:0] v);
    @(negedge clk);
    valid = 1'b1; dest = d; src = s; op = o; data = v;
    @(negedge clk);
    valid = 1'b0; op = NOP; data = '0;
  endtask

  task automatic peek(input logic [3:0] a, input logic [15:0] exp, input string tag);
    rd_addr = a;
    #1;
    chk(32'(rd_data), 32'(exp), tag);
  endtask

  task automatic finish_write(input string tag);
    repeat (WRC - 1) @(negedge clk);
    chk(32'(rdy), 32'd0, {tag, " R9 busy at last write cycle"});
    @(negedge clk);
    chk(32'(rdy), 32'd1, {tag, " R6 ready after write"});
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(32'(rdy), 32'd1, "R1 ready after reset");
    peek(4'd0, 16'h0, "R1 ram zero addr0");
    peek(4'd15, 16'h0, "R1 ram zero addr15");

    // table walk: R2, R5, R6, R9
    for (int i = 0; i < NV; i++) begin
      xfer(ME, V_SRC[i], WR, 16'(V_ADDR[i]));
      chk(32'(rdy), 32'd0, "R2 ready low after address");
      xfer(ME, V_SRC[i], V_DOP[i], V_DATA[i]);
      chk(32'(rdy), 32'd0, "R9 ready low after operand");
      finish_write("vec");
      peek(V_ADDR[i], V_DATA[i], "R5 R6 operand stored");
    end

    // R7 foreign destination while idle
    xfer(3'd2, 3'd1, WR, 16'h0008);
    chk(32'(rdy), 32'd1, "R7 idle foreign dest keeps ready");
    xfer(3'd2, 3'd1, NOP, 16'hDEAD);
    chk(32'(rdy), 32'd1, "R7 idle foreign operand ignored");
    peek(4'd8, 16'h0, "R7 ram untouched");

    // R8 non-write opcodes ignored while idle
    xfer(ME, 3'd1, RD, 16'h0009);
    chk(32'(rdy), 32'd1, "R8 read opcode ignored");
    xfer(ME, 3'd1, NOP, 16'h0009);
    chk(32'(rdy), 32'd1, "R8 nop opcode ignored");
    xfer(ME, 3'd1, CMD, 16'h0009);
    chk(32'(rdy), 32'd1, "R8 cmd opcode ignored");

    // R7 foreign destination while locked
    xfer(ME, 3'd1, WR, 16'h0009);
    xfer(3'd6, 3'd1, NOP, 16'hBEEF);
    chk(32'(rdy), 32'd0, "R7 locked foreign dest no effect");
    repeat (WRC + 1) @(negedge clk);
    chk(32'(rdy), 32'd0, "R7 lock held after foreign operand");
    peek(4'd9, 16'h0, "R7 no write from foreign operand");
    xfer(ME, 3'd1, NOP, 16'h7777);
    finish_write("R7");
    peek(4'd9, 16'h7777, "R7 proper operand stored");

    // R4 wrong source while locked
    xfer(ME, 3'd2, WR, 16'h000A);
    xfer(ME, 3'd6, NOP, 16'h0BAD);
    chk(32'(rdy), 32'd0, "R4 wrong source keeps lock");
    repeat (WRC + 1) @(negedge clk);
    chk(32'(rdy), 32'd0, "R4 lock still held");
    peek(4'd10, 16'h0, "R4 wrong-source operand dropped");
    xfer(ME, 3'd2, NOP, 16'h4321);
    finish_write("R4");
    peek(4'd10, 16'h4321, "R4 right-source operand stored");

    // R3 second requester address during lock
    xfer(ME, 3'd3, WR, 16'h000B);
    xfer(ME, 3'd4, WR, 16'h000C);
    chk(32'(rdy), 32'd0, "R3 second address not taken");
    xfer(ME, 3'd3, NOP, 16'h5A5A);
    finish_write("R3");
    peek(4'd11, 16'h5A5A, "R3 locked address used");
    peek(4'd12, 16'h0, "R3 other address untouched");

    // R1 reset mid-access returns to idle and clears RAM
    xfer(ME, 3'd1, WR, 16'h000D);
    rst_n = 1'b0;
    #1;
    chk(32'(rdy), 32'd1, "R1 reset releases lock");
    peek(4'd11, 16'h0, "R1 reset clears ram");
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule